// File: doc/BRIEF.md
# Receive FIFO DMA Request Scheduler

Several serial framing channels write into one shared receive FIFO. This block watches each channel's fill count and decides when that channel has enough data to move to host memory. A channel qualifies when its count is strictly above a programmable high watermark, or when it holds a completed frame and has at least one byte stored. A frame can be shorter than the watermark, and the second rule keeps such a frame from waiting in the FIFO.

When one or more channels qualify, the block raises a request. The request carries the chosen channel and a burst length equal to that channel's whole fill count, so the DMA engine empties the channel in one burst even when the data spans several frames. The block cannot take the bus by itself. It waits for the DMA engine's grant, then holds the channel and length steady until the engine reports that the burst is done. At run time one input chooses between a fixed priority, in which the lowest channel index wins, and a rotating order.

Top module: `rxq_dma_sched`

## Requirements
- R1: After a synchronous active-low reset, `req_valid` and `xfer_active` are 0, no frame end is recorded, and the rotating search starts at channel 0.
- R2: A channel with no recorded frame end is eligible only when its fill count is strictly greater than `high_wm`. A count equal to `high_wm` is not enough.
- R3: A `eof_in[i]` pulse records a frame end for channel i. While that record is held and the fill count is nonzero, the channel is eligible whatever the watermark.
- R4: With `rr_mode` = 0 (fixed priority), the eligible channel with the lowest index is offered.
- R5: With `rr_mode` = 1 (rotating), the search starts one channel past the channel whose burst completed last and wraps at NUM_CH-1. The pointer advances only on a completed burst.
- R6: `req_len` equals the full current fill count of the offered channel.
- R7: A grant is taken only in a cycle where `req_valid` is 1. On the next cycle `xfer_active` is 1, and `req_chan` and `req_len` hold the values sampled at the grant until the burst ends. A grant while `req_valid` is 0 has no effect.
- R8: `dma_done` while `xfer_active` is 1 clears `xfer_active` on the next cycle. `dma_done` while idle has no effect.
- R9: A frame end recorded before the grant cycle is consumed by that burst. A frame end that arrives in the grant cycle or during the burst stays recorded after the burst.
- R10: `req_valid` is 0 whenever no channel is eligible and whenever a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_cnt | input | NUM_CH*CNT_W | Per-channel FIFO fill counts; channel i occupies bits [i*CNT_W +: CNT_W] |
| eof_in | input | NUM_CH | One-cycle pulse per channel: a frame end was written to the FIFO |
| high_wm | input | CNT_W | High watermark; a count above it makes a channel eligible |
| rr_mode | input | 1 | 0 = fixed priority, 1 = rotating |
| dma_grant | input | 1 | DMA engine accepts the current request |
| dma_done | input | 1 | DMA engine finished the current burst |
| req_valid | output | 1 | A request is offered |
| req_chan | output | $clog2(NUM_CH) | Offered channel, or the latched channel during a burst |
| req_len | output | CNT_W | Burst length, or the latched length during a burst |
| xfer_active | output | 1 | A granted burst is in progress |

## Verification
The bench tests the watermark boundary at equality. A design that compares with `>=` would request one byte early. It checks that a short frame is released by its frame-end record and that the record is consumed by exactly one burst. A design that clears the record too late leaves the channel eligible forever, and one that clears it too early drops a frame end that arrives during a burst. It checks the rotating order after completed bursts and while a grant is held off; a pointer that moves on a grant or on every cycle serves channels in the wrong order. It also checks that the latched length does not follow a fill count that drains during the burst, and that a stray grant or done signal leaves the block unchanged.

// File: rtl/rxq_sched_pkg.sv
// Package: shared types for the receive FIFO DMA request scheduler.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package rxq_sched_pkg;

    // Arbitration mode as carried on rr_mode
    typedef enum logic {
        ARB_FIXED  = 1'b0,
        ARB_ROTATE = 1'b1
    } arb_mode_e;

    // Burst controller state
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

endpackage

// File: rtl/rxq_ready.sv
// Module: rxq_ready
// Purpose: keeps one frame-end record per channel and works out which
//          channels are eligible for a DMA burst.
// Assumes: fill counts come straight from the FIFO pointer logic. eof_in is
//          a single-cycle pulse. clr_mask has at most one bit set, in the
//          cycle a grant is taken.
module rxq_ready #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*CNT_W-1:0] fill_cnt,
    input  logic [NUM_CH-1:0]       eof_in,
    input  logic [CNT_W-1:0]        high_wm,
    input  logic [NUM_CH-1:0]       clr_mask,
    output logic [NUM_CH-1:0]       ready
);

    logic [NUM_CH-1:0] eof_seen;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic [CNT_W-1:0] cnt;
        assign cnt = fill_cnt[gi*CNT_W +: CNT_W];

        // Frame-end record: a new pulse wins over the clear of the grant cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                eof_seen[gi] <= 1'b0;
            end else begin
                eof_seen[gi] <= (eof_seen[gi] & ~clr_mask[gi]) | eof_in[gi];
            end
        end

        // Eligibility: above the watermark, or a held frame end with data stored
        always_comb begin
            ready[gi] = (cnt > high_wm) | (eof_seen[gi] & (cnt != '0));
        end
    end

endmodule

// File: rtl/rxq_arb.sv
// Module: rxq_arb
// Purpose: picks one channel from the eligible set, by fixed priority
//          (lowest index first) or by rotation starting past last_ch.
// Assumes: last_ch < NUM_CH. Purely combinational.
module rxq_arb
    import rxq_sched_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [NUM_CH-1:0] ready,
    input  logic              rr_mode,
    input  logic [CH_W-1:0]   last_ch,
    output logic [CH_W-1:0]   pick,
    output logic              any
);

    logic [CH_W-1:0] fix_pick;
    logic [CH_W-1:0] rot_pick;
    arb_mode_e       mode;

    assign mode = arb_mode_e'(rr_mode);
    assign any  = |ready;

    // Fixed priority: scan from the top down so the lowest index is kept last
    always_comb begin
        fix_pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ready[i]) begin
                fix_pick = CH_W'(i);
            end
        end
    end

    // Rotation: scan offsets NUM_CH down to 1 past last_ch so the nearest offset is kept last
    always_comb begin
        rot_pick = '0;
        for (int k = NUM_CH; k >= 1; k--) begin
            int idx;
            idx = (int'(last_ch) + k) % NUM_CH;
            if (ready[idx]) begin
                rot_pick = CH_W'(idx);
            end
        end
    end

    // Output select by run-time mode
    always_comb begin
        pick = (mode == ARB_ROTATE) ? rot_pick : fix_pick;
    end

endmodule

// File: rtl/rxq_burst_ctrl.sv
// Module: rxq_burst_ctrl
// Purpose: offers the arbiter's pick to the DMA engine, latches channel and
//          length on grant, holds them until done, and moves the rotation
//          pointer when a burst completes.
// Assumes: dma_grant counts only while req_valid is high. dma_done counts
//          only while a burst is active.
module rxq_burst_ctrl
    import rxq_sched_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any,
    input  logic [CH_W-1:0]   pick,
    input  logic [CNT_W-1:0]  pick_len,
    input  logic              dma_grant,
    input  logic              dma_done,
    output logic              req_valid,
    output logic [CH_W-1:0]   req_chan,
    output logic [CNT_W-1:0]  req_len,
    output logic              xfer_active,
    output logic [CH_W-1:0]   last_ch,
    output logic [NUM_CH-1:0] clr_mask
);

    localparam logic [CH_W-1:0] LAST_RST = CH_W'(NUM_CH - 1);

    burst_state_e     state;
    logic [CH_W-1:0]  lat_chan;
    logic [CNT_W-1:0] lat_len;
    logic             take;
    logic             finish;

    assign take   = (state == ST_IDLE) & any & dma_grant;
    assign finish = (state == ST_BURST) & dma_done;

    // State, latched selection and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_chan <= '0;
            lat_len  <= '0;
            last_ch  <= LAST_RST;
        end else if (take) begin
            state    <= ST_BURST;
            lat_chan <= pick;
            lat_len  <= pick_len;
        end else if (finish) begin
            state    <= ST_IDLE;
            last_ch  <= lat_chan;
        end
    end

    // Frame-end clear: a one-hot mask for the channel granted this cycle
    always_comb begin
        clr_mask = '0;
        if (take) begin
            clr_mask[pick] = 1'b1;
        end
    end

    // Outputs: the live offer while idle, the latched values while bursting
    always_comb begin
        xfer_active = (state == ST_BURST);
        req_valid   = (state == ST_IDLE) & any;
        req_chan    = xfer_active ? lat_chan : pick;
        req_len     = xfer_active ? lat_len  : pick_len;
    end

endmodule

// File: rtl/rxq_dma_sched.sv
// Module: rxq_dma_sched (top)
// Purpose: receive FIFO DMA request scheduler. Decides which channel's data
//          is ready and offers it, with its full fill count, to the DMA engine.
// Assumes: fill_cnt reflects the shared FIFO each cycle. The DMA engine
//          drains the offered length, and the fill count falls as it does.
module rxq_dma_sched #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*CNT_W-1:0] fill_cnt,
    input  logic [NUM_CH-1:0]       eof_in,
    input  logic [CNT_W-1:0]        high_wm,
    input  logic                    rr_mode,
    input  logic                    dma_grant,
    input  logic                    dma_done,
    output logic                    req_valid,
    output logic [CH_W-1:0]         req_chan,
    output logic [CNT_W-1:0]        req_len,
    output logic                    xfer_active
);

    logic [NUM_CH-1:0] ready;
    logic [NUM_CH-1:0] clr_mask;
    logic [CH_W-1:0]   pick;
    logic [CH_W-1:0]   last_ch;
    logic              any;
    logic [CNT_W-1:0]  pick_len;

    rxq_ready #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ready (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_cnt (fill_cnt),
        .eof_in   (eof_in),
        .high_wm  (high_wm),
        .clr_mask (clr_mask),
        .ready    (ready)
    );

    rxq_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
        .ready   (ready),
        .rr_mode (rr_mode),
        .last_ch (last_ch),
        .pick    (pick),
        .any     (any)
    );

    // Length mux: the full fill count of the picked channel
    always_comb begin
        pick_len = fill_cnt[int'(pick)*CNT_W +: CNT_W];
    end

    rxq_burst_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .any         (any),
        .pick        (pick),
        .pick_len    (pick_len),
        .dma_grant   (dma_grant),
        .dma_done    (dma_done),
        .req_valid   (req_valid),
        .req_chan    (req_chan),
        .req_len     (req_len),
        .xfer_active (xfer_active),
        .last_ch     (last_ch),
        .clr_mask    (clr_mask)
    );

endmodule

// File: rtl/rxq_dma_sched_chk.sv
// Module: rxq_dma_sched_chk
// Purpose: temporal properties of the scheduler's port behaviour, bound to
//          every instance of rxq_dma_sched.
// Assumes: synchronous active-low reset. All properties are disabled during reset.
module rxq_dma_sched_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 8,
    parameter int CH_W   = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH*CNT_W-1:0] fill_cnt,
    input logic [CNT_W-1:0]        high_wm,
    input logic                    dma_grant,
    input logic                    dma_done,
    input logic                    req_valid,
    input logic [CH_W-1:0]         req_chan,
    input logic [CNT_W-1:0]        req_len,
    input logic                    xfer_active
);

    AST_NO_REQ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> !req_valid); // R10

    AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dma_grant) |=> xfer_active); // R7

    AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active) |-> $past(req_valid && dma_grant)); // R7

    AST_HOLD_SELECTION: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && $past(xfer_active)) |-> ($stable(req_chan) && $stable(req_len))); // R7

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && dma_done) |=> !xfer_active); // R8

    AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !dma_done) |=> xfer_active); // R8

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0)); // R6

    AST_LEN_IS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len == fill_cnt[int'(req_chan)*CNT_W +: CNT_W])); // R6

endmodule

bind rxq_dma_sched rxq_dma_sched_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_cnt    (fill_cnt),
    .high_wm     (high_wm),
    .dma_grant   (dma_grant),
    .dma_done    (dma_done),
    .req_valid   (req_valid),
    .req_chan    (req_chan),
    .req_len     (req_len),
    .xfer_active (xfer_active)
);

// File: tb/rxq_dma_sched_bench.sv
// Bench for rxq_dma_sched: a behavioural reference model is compared with the
// design on every clock, and directed checks carry explicit expected values.
module rxq_dma_sched_bench;

    localparam int N  = 4;
    localparam int CW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*CW-1:0] fill_cnt;
    logic [N-1:0]    eof_in = '0;
    logic [CW-1:0]   high_wm = 8'd10;
    logic            rr_mode = 1'b0;
    logic            dma_grant = 1'b0;
    logic            dma_done = 1'b0;
    logic            req_valid;
    logic [1:0]      req_chan;
    logic [CW-1:0]   req_len;
    logic            xfer_active;

    int fill_m [N];
    int checks = 0;
    int fails = 0;

    // Reference model state
    bit m_eof [N];
    bit m_busy;
    int m_last;
    int m_lchan;
    int m_llen;

    always #2 clk = ~clk;   // 250 MHz

    rxq_dma_sched #(.NUM_CH(N), .CNT_W(CW)) u_rxq_dma_sched (
        .clk(clk), .rst_n(rst_n), .fill_cnt(fill_cnt), .eof_in(eof_in),
        .high_wm(high_wm), .rr_mode(rr_mode), .dma_grant(dma_grant),
        .dma_done(dma_done), .req_valid(req_valid), .req_chan(req_chan),
        .req_len(req_len), .xfer_active(xfer_active)
    );

    always_comb begin
        for (int i = 0; i < N; i++) fill_cnt[i*CW +: CW] = CW'(fill_m[i]);
    end

    function automatic bit m_ready(int c);
        return (fill_m[c] > int'(high_wm)) || (m_eof[c] && fill_m[c] != 0);
    endfunction

    function automatic int m_pick(output bit any);
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = rr_mode ? (m_last + 1 + k) % N : k;
            if (m_ready(c)) begin
                any = 1'b1;
                return c;
            end
        end
        return 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare the design with the model (inputs settled, before the edge)
    task automatic compare();
        bit any;
        int p;
        p = m_pick(any);
        chk(xfer_active == m_busy, "R7 R8 xfer_active", int'(xfer_active), int'(m_busy));
        chk(req_valid == (!m_busy && any), "R10 R2 R3 req_valid", int'(req_valid), int'(!m_busy && any));
        if (m_busy) begin
            chk(int'(req_chan) == m_lchan, "R7 held req_chan", int'(req_chan), m_lchan);
            chk(int'(req_len) == m_llen, "R7 held req_len", int'(req_len), m_llen);
        end else if (any) begin
            chk(int'(req_chan) == p, "R4 R5 req_chan", int'(req_chan), p);
            chk(int'(req_len) == fill_m[p], "R6 req_len", int'(req_len), fill_m[p]);
        end
    endtask

    // Model update with the inputs present at the edge
    task automatic model_edge();
        bit any;
        int p;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_eof[i] = 1'b0;
            m_busy = 1'b0; m_last = N - 1; m_lchan = 0; m_llen = 0;
            return;
        end
        p = m_pick(any);
        if (!m_busy && any && dma_grant) begin
            m_busy = 1'b1; m_lchan = p; m_llen = fill_m[p];
            m_eof[p] = 1'b0;
        end else if (m_busy && dma_done) begin
            m_busy = 1'b0; m_last = m_lchan;
        end
        for (int i = 0; i < N; i++) if (eof_in[i]) m_eof[i] = 1'b1;
    endtask

    task automatic tick();
        #1;
        if (rst_n) compare();
        @(posedge clk);
        model_edge();
        #1;
    endtask

    // Directed check of the outputs against explicit values
    task automatic expect_out(bit v, int ch, int len, bit act, string tag);
        #0.5;
        chk(req_valid == v, {tag, " valid"}, int'(req_valid), int'(v));
        chk(xfer_active == act, {tag, " active"}, int'(xfer_active), int'(act));
        if (v || act) begin
            chk(int'(req_chan) == ch, {tag, " chan"}, int'(req_chan), ch);
            chk(int'(req_len) == len, {tag, " len"}, int'(req_len), len);
        end
    endtask

    task automatic grant_once();
        dma_grant = 1'b1; tick(); dma_grant = 1'b0;
    endtask

    task automatic done_once();
        dma_done = 1'b1; tick(); dma_done = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) fill_m[i] = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        expect_out(0, 0, 0, 0, "R1 reset");
        tick();
        expect_out(0, 0, 0, 0, "R10 all empty");
        tick();

        // R2 watermark boundary
        fill_m[2] = 10; expect_out(0, 0, 0, 0, "R2 equal wm"); tick();
        fill_m[2] = 11; expect_out(1, 2, 11, 0, "R2 R6 above wm"); tick();
        grant_once();
        fill_m[2] = 5; expect_out(0, 2, 11, 1, "R7 len latched"); tick(); tick();
        fill_m[2] = 0; done_once();
        expect_out(0, 0, 0, 0, "R8 after done"); tick();

        // R4 fixed priority
        fill_m[1] = 20; fill_m[3] = 30; expect_out(1, 1, 20, 0, "R4 lowest first"); tick();
        grant_once(); tick();
        fill_m[1] = 0; done_once();
        expect_out(1, 3, 30, 0, "R4 next"); tick();
        grant_once(); fill_m[3] = 0; done_once();

        // R5 rotation: last completed was 3, so search starts at 0
        rr_mode = 1'b1;
        for (int i = 0; i < N; i++) fill_m[i] = 50;
        expect_out(1, 0, 50, 0, "R5 wrap to 0"); tick(); tick(); tick();
        expect_out(1, 0, 50, 0, "R5 pointer still"); tick();
        grant_once(); done_once();
        expect_out(1, 1, 50, 0, "R5 advance"); tick();
        grant_once(); tick(); done_once();
        expect_out(1, 2, 50, 0, "R5 advance again"); tick();
        rr_mode = 1'b0;
        expect_out(1, 0, 50, 0, "R4 back to fixed"); tick();
        for (int i = 0; i < N; i++) fill_m[i] = 0;
        tick();

        // R3 and R9 frame-end handling
        fill_m[0] = 3; expect_out(0, 0, 0, 0, "R3 short no eof"); tick();
        eof_in[0] = 1'b1; tick(); eof_in[0] = 1'b0;
        expect_out(1, 0, 3, 0, "R3 eof releases"); tick();
        grant_once();
        eof_in[0] = 1'b1; tick(); eof_in[0] = 1'b0;
        fill_m[0] = 2; done_once();
        expect_out(1, 0, 2, 0, "R9 late eof kept"); tick();
        grant_once(); done_once();
        expect_out(0, 0, 0, 0, "R9 eof consumed"); tick();
        fill_m[0] = 0;
        eof_in[1] = 1'b1; tick(); eof_in[1] = 1'b0;
        expect_out(0, 0, 0, 0, "R3 eof without data"); tick();
        fill_m[1] = 4; expect_out(1, 1, 4, 0, "R3 eof held until data"); tick();
        grant_once(); fill_m[1] = 0; done_once();

        // R7 and R8 stray controls
        grant_once();
        expect_out(0, 0, 0, 0, "R7 grant ignored"); tick();
        done_once();
        fill_m[3] = 12;
        expect_out(1, 3, 12, 0, "R8 done ignored"); tick();
        repeat (4) tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule